// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block lets a host reach the management registers of external Ethernet PHYs over a two-wire serial management line. The host side is a plain 32-bit register port with a write strobe and a separate read address. The line side drives a management clock (MDC) and a tri-stateable data line, split into output value, output enable and input. A configuration register selects the frame format, which is either the short clause 22 format or the indirect clause 45 format. The same register also holds the MDC divider and a drive-option bit.

Software programs the PHY port and device fields in the control register. In clause 45 mode, writing the address register sends an address frame. Writing the data register sends a write frame. Writing the control register with its read bit set sends a read frame, and the received 16 bits land in the data register. Software polls a busy flag between steps. A read-error flag reports that no PHY answered.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset every readable field is zero: busy, read error, clause-45 select (bit 4 of the config register, offset 0), drive option (bit 5) and divider (bits 24:16). In the control register (offset 1) and in the data (offset 2) and address (offset 3) registers, every field reads zero. MDC and the MDIO output enable are low.
- R2: Every frame is 64 MDC cycles: 32 ones, a 2-bit start, a 2-bit op, a 5-bit port, a 5-bit device/register field, a 2-bit turnaround and 16 data bits, sent MSB first. Start is 01 in clause 22 (select bit 0) and 00 in clause 45 (select bit 1). Op is 01 for a clause 22 write, 10 for a clause 22 read, 00 for a clause 45 address, 01 for a clause 45 write and 11 for a clause 45 read.
- R3: In clause 22 mode the control field at bits 4:0 is sent as the register number, and a write to the address register stores the value but launches no frame.
- R4: In clause 45 mode a write to the address register launches an address frame that carries bits 15:0 of the written word, with turnaround 10.
- R5: A write to the data register launches a write frame with turnaround 10, carrying bits 15:0 of the written word. The data register then reads back that value.
- R6: A control write with bit 15 set launches a read frame to the port in bits 12:8 and device in bits 4:0. The master releases MDIO for both turnaround bits and all 16 data bits, and the 16 bits sampled from the PHY then read back in the data register.
- R7: Busy (config bit 0) rises on the clock edge that accepts a launching write. It stays high until the falling MDC edge that ends bit 64. MDC is low and the output enable is off whenever busy is clear.
- R8: If MDIO is not low at the second turnaround bit of a read, config bit 1 is set and the data register reads 0xFFFF. The flag clears when the next read launches.
- R9: Each MDC half-period lasts the divider value in system clocks. A divider of zero holds MDC low and stalls a frame in progress until a non-zero value is written.
- R10: MDIO output changes only together with a falling MDC edge, or at frame launch. The master samples MDIO on the rising MDC edge.
- R11: While busy is set, writes to the control, data and address registers are ignored. Config register writes are always taken.
- R12: The drive-option bit (config bit 5) is writable and reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write register select: 0 config, 1 control, 2 data, 3 address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read register select, same encoding |
| reg_rdata | output | 32 | Read data for reg_raddr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
A table of frames runs all five formats: the two clause 22 types and the three clause 45 types. Port, device and data values cover all-zeros, all-ones and mixed patterns. A responder captures each frame bit by bit, so a wrong start, op, field order or turnaround shows up as a difference in the 32 header-and-data bits. Directed cases check the points where the frame types differ in behaviour:
- an absent PHY, which must raise the read error and force the data register to ones;
- a zero divider, which must stall the frame, while writes that arrive during the stall are dropped and cannot alter the frame;
- an address-register write in clause 22 mode, which must stay silent on the line;
- a measured MDC half-period.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CTL  = 2'd1,
    REG_DATA = 2'd2,
    REG_ADDR = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_e;

  localparam int HDR_BITS     = 32;
  localparam int FLD_W        = 5;
  localparam int CFG_BUSY_BIT = 0;
  localparam int CFG_ERR_BIT  = 1;
  localparam int CFG_C45_BIT  = 4;
  localparam int CFG_NEG_BIT  = 5;
  localparam int CFG_DIV_LSB  = 16;
  localparam int CTL_DEV_LSB  = 0;
  localparam int CTL_PORT_LSB = 8;
  localparam int CTL_RD_BIT   = 15;

  // start, op, port, device, turnaround and payload, MSB first
  function automatic logic [HDR_BITS-1:0] build_hdr(
      input logic             c45,
      input frame_kind_e      kind,
      input logic [FLD_W-1:0] port,
      input logic [FLD_W-1:0] dev,
      input logic [15:0]      payload);
    logic [1:0]  st;
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] pl;
    st = c45 ? 2'b00 : 2'b01;
    case (kind)
      FR_ADDR:  op = 2'b00;
      FR_WRITE: op = 2'b01;
      FR_READ:  op = c45 ? 2'b11 : 2'b10;
      default:  op = 2'b00;
    endcase
    ta = (kind == FR_READ) ? 2'b11 : 2'b10;
    pl = (kind == FR_READ) ? 16'hFFFF : payload;
    return {st, op, port, dev, ta, pl};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_tk_o,
  output logic             fall_tk_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  always_comb begin
    cnt_d     = cnt_q;
    mdc_d     = mdc_q;
    rise_tk_o = 1'b0;
    fall_tk_o = 1'b0;
    if (!run_i || (div_i == '0)) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_q >= div_i - 1'b1) begin
      cnt_d     = '0;
      mdc_d     = ~mdc_q;
      rise_tk_o = ~mdc_q;
      fall_tk_o = mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o = mdc_q;

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter #(
  parameter int FRAME_LEN = 64,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 is_read_i,
  input  logic                 rise_tk_i,
  input  logic                 fall_tk_i,
  input  logic                 mdio_i,
  output logic                 busy_o,
  output logic                 rd_frame_o,
  output logic [IDX_W-1:0]     bit_idx_o,
  output logic                 mdio_o,
  output logic                 mdio_oe_o,
  output logic                 rd_done_o,
  output logic [15:0]          rx_data_o,
  output logic                 rx_err_o
);

  localparam int TA_POS  = FRAME_LEN - 18;
  localparam int TA2_POS = TA_POS + 1;
  localparam int LAST    = FRAME_LEN - 1;

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 oe_q, oe_d;
  logic [15:0]          rx_q, rx_d;
  logic                 err_q, err_d;
  logic                 done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    oe_d   = oe_q;
    rx_d   = rx_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        rd_d   = is_read_i;
        sh_d   = frame_i;
        idx_d  = '0;
        oe_d   = 1'b1;
        if (is_read_i) err_d = 1'b0;
      end
    end else begin
      if (rise_tk_i && rd_q) begin
        if (idx_q == IDX_W'(TA2_POS)) begin
          err_d = mdio_i;
        end else if (idx_q > IDX_W'(TA2_POS)) begin
          rx_d = {rx_q[14:0], mdio_i};
        end
      end
      if (fall_tk_i) begin
        if (idx_q == IDX_W'(LAST)) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          done_d = rd_q;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
          oe_d  = !(rd_q && (idx_q >= IDX_W'(TA_POS - 1)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      oe_q   <= 1'b0;
      rx_q   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      oe_q   <= oe_d;
      rx_q   <= rx_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign busy_o     = busy_q;
  assign rd_frame_o = rd_q;
  assign bit_idx_o  = idx_q;
  assign mdio_o     = sh_q[FRAME_LEN-1];
  assign mdio_oe_o  = oe_q;
  assign rd_done_o  = done_q;
  assign rx_data_o  = rx_q;
  assign rx_err_o   = err_q;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 9,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FRAME_LEN = PRE_LEN + HDR_BITS;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  logic             c45_q, c45_d;
  logic             neg_q, neg_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [FLD_W-1:0] port_q, port_d;
  logic [FLD_W-1:0] dev_q, dev_d;
  logic [15:0]      data_q, data_d;
  logic [15:0]      addr_q, addr_d;

  logic                 busy, rd_frame, rd_done, rx_err;
  logic [IDX_W-1:0]     bit_idx;
  logic [15:0]          rx_data;
  logic                 rise_tk, fall_tk;
  logic                 start;
  frame_kind_e          kind;
  logic [FRAME_LEN-1:0] frame;

  always_comb begin
    c45_d  = c45_q;
    neg_d  = neg_q;
    div_d  = div_q;
    port_d = port_q;
    dev_d  = dev_q;
    data_d = data_q;
    addr_d = addr_q;
    start  = 1'b0;
    kind   = FR_WRITE;
    if (reg_wr) begin
      case (reg_sel_e'(reg_waddr))
        REG_CFG: begin
          c45_d = reg_wdata[CFG_C45_BIT];
          neg_d = reg_wdata[CFG_NEG_BIT];
          div_d = reg_wdata[CFG_DIV_LSB +: DIV_W];
        end
        REG_CTL: if (!busy) begin
          port_d = reg_wdata[CTL_PORT_LSB +: FLD_W];
          dev_d  = reg_wdata[CTL_DEV_LSB +: FLD_W];
          if (reg_wdata[CTL_RD_BIT]) begin
            start = 1'b1;
            kind  = FR_READ;
          end
        end
        REG_DATA: if (!busy) begin
          data_d = reg_wdata[15:0];
          start  = 1'b1;
          kind   = FR_WRITE;
        end
        REG_ADDR: if (!busy) begin
          addr_d = reg_wdata[15:0];
          if (c45_q) begin
            start = 1'b1;
            kind  = FR_ADDR;
          end
        end
        default: ;
      endcase
    end
    if (rd_done) data_d = rx_err ? 16'hFFFF : rx_data;
  end

  assign frame = {{PRE_LEN{1'b1}},
                  build_hdr(c45_q, kind, port_d, dev_d, reg_wdata[15:0])};

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      c45_q  <= 1'b0;
      neg_q  <= 1'b0;
      div_q  <= '0;
      port_q <= '0;
      dev_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      c45_q  <= c45_d;
      neg_q  <= neg_d;
      div_q  <= div_d;
      port_q <= port_d;
      dev_q  <= dev_d;
      data_q <= data_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_e'(reg_raddr))
      REG_CFG: begin
        reg_rdata[CFG_BUSY_BIT]             = busy;
        reg_rdata[CFG_ERR_BIT]              = rx_err;
        reg_rdata[CFG_C45_BIT]              = c45_q;
        reg_rdata[CFG_NEG_BIT]              = neg_q;
        reg_rdata[CFG_DIV_LSB +: DIV_W]     = div_q;
      end
      REG_CTL: begin
        reg_rdata[CTL_PORT_LSB +: FLD_W] = port_q;
        reg_rdata[CTL_DEV_LSB +: FLD_W]  = dev_q;
      end
      REG_DATA: reg_rdata[15:0] = data_q;
      REG_ADDR: reg_rdata[15:0] = addr_q;
      default:  reg_rdata = '0;
    endcase
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .run_i     (busy),
    .div_i     (div_q),
    .mdc_o     (mdc),
    .rise_tk_o (rise_tk),
    .fall_tk_o (fall_tk)
  );

  mdio_frame_shifter #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start),
    .frame_i    (frame),
    .is_read_i  (kind == FR_READ),
    .rise_tk_i  (rise_tk),
    .fall_tk_i  (fall_tk),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .rd_frame_o (rd_frame),
    .bit_idx_o  (bit_idx),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe),
    .rd_done_o  (rd_done),
    .rx_data_o  (rx_data),
    .rx_err_o   (rx_err)
  );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int DIV_W     = 9,
  parameter int FRAME_LEN = 64,
  parameter int IDX_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic [DIV_W-1:0] div_q,
  input logic             rd_frame,
  input logic [IDX_W-1:0] bit_idx,
  input logic [4:0]       port_q,
  input logic [4:0]       dev_q,
  input logic             reg_wr
);

  localparam int TA_POS = FRAME_LEN - 18;

  a_r7_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  a_r7_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r7_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));

  a_r9_div_zero_stops_mdc: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> !mdc);

  a_r10_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  a_r6_release_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_frame && (bit_idx >= IDX_W'(TA_POS))) |-> !mdio_oe);

  a_r11_ctl_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(port_q) && $stable(dev_q)));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(
  .DIV_W(DIV_W), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .div_q    (div_q),
  .rd_frame (rd_frame),
  .bit_idx  (bit_idx),
  .port_q   (port_q),
  .dev_q    (dev_q),
  .reg_wr   (reg_wr)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // responder: pull-up line, captures each bit on MDC rise, answers reads
  logic        phy_present = 1'b1;
  logic [15:0] phy_rdata = '0;
  logic        phy_drv = 1'b0;
  logic        phy_val = 1'b1;
  logic        phy_rd = 1'b0;
  logic [63:0] cap = '0;
  int          pos = 0;
  int          rises = 0;
  wire         line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);
  assign mdio_i = line;

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    if (pos == 35) phy_rd = (cap[3:0] == 4'b0110) || (cap[3:0] == 4'b0011);
    if (phy_rd && phy_present) begin
      if (pos == 46) begin
        phy_drv = 1'b1;
        phy_val = 1'b0;
      end else if (pos >= 47 && pos <= 62) begin
        phy_val = phy_rdata[62 - pos];
      end
    end
    if (pos == 63) begin
      phy_drv = 1'b0;
      phy_rd  = 1'b0;
    end
    pos   = (pos == 63) ? 0 : pos + 1;
    rises = rises + 1;
  end

  // line-edge monitor for R10
  int   bad_edges = 0;
  logic prev_o = 1'b0, prev_oe = 1'b0, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (mdio_oe && prev_oe && (mdio_o !== prev_o) && !(prev_mdc && !mdc))
      bad_edges = bad_edges + 1;
    prev_o   = mdio_o;
    prev_oe  = mdio_oe;
    prev_mdc = mdc;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_raddr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [31:0] cfgw(input logic c45, input logic neg, input int dv);
    return (32'(dv) << 16) | (32'(neg) << 5) | (32'(c45) << 4);
  endfunction

  // kind: 0 c22 write, 1 c22 read, 2 c45 addr, 3 c45 write, 4 c45 read
  // fields: kind, port, dev, value, expected 32 bits after preamble
  localparam logic [60:0] VEC [0:6] = '{
    {3'd0, 5'h01, 5'h04, 16'hA5C3, 32'h5092A5C3},
    {3'd1, 5'h1F, 5'h1F, 16'h1234, 32'h6FFE1234},
    {3'd2, 5'h03, 5'h01, 16'h0010, 32'h01860010},
    {3'd3, 5'h03, 5'h01, 16'hBEEF, 32'h1186BEEF},
    {3'd4, 5'h03, 5'h01, 16'h8001, 32'h31868001},
    {3'd0, 5'h10, 5'h0A, 16'h0000, 32'h582A0000},
    {3'd2, 5'h1F, 5'h1F, 16'hFFFF, 32'h0FFEFFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog: actual hung expected idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          cnt;
    int          r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 cfg", v, 0);
    rd(2'd1, v); check("R1 ctl", v, 0);
    rd(2'd2, v); check("R1 data", v, 0);
    rd(2'd3, v); check("R1 addr", v, 0);
    check("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);

    // R12 drive option bit
    wr(2'd0, cfgw(1'b0, 1'b1, 2));
    rd(2'd0, v); check("R12 neg set", v[5], 1'b1);
    wr(2'd0, cfgw(1'b0, 1'b0, 2));
    rd(2'd0, v); check("R12 neg clear", v[5], 1'b0);

    // table of frames: R2 R3 R4 R5 R6
    for (int k = 0; k < 7; k++) begin
      logic [2:0]  kd;
      logic [4:0]  pt, dv;
      logic [15:0] val;
      logic [31:0] ex;
      {kd, pt, dv, val, ex} = VEC[k];
      wr(2'd0, cfgw(kd >= 3'd2, k[0], 2));
      phy_rdata = val;
      case (kd)
        3'd0, 3'd3: begin wr(2'd1, {19'b0, pt, 3'b0, dv}); wr(2'd2, {16'b0, val}); end
        3'd2:       begin wr(2'd1, {19'b0, pt, 3'b0, dv}); wr(2'd3, {16'b0, val}); end
        default:    wr(2'd1, {16'b0, 1'b1, 2'b0, pt, 3'b0, dv});
      endcase
      rd(2'd0, v); check("R7 busy after launch", v[0], 1'b1);
      wait_idle();
      check("R2 preamble", cap[63:32], 32'hFFFFFFFF);
      check("R2 frame bits", cap[31:0], ex);
      check("R7 full frame length", pos, 0);
      if (kd == 3'd1 || kd == 3'd4) begin
        rd(2'd2, v); check("R6 read data", v, {16'b0, val});
        rd(2'd0, v); check("R8 no error", v[1], 1'b0);
      end else if (kd == 3'd2) begin
        rd(2'd3, v); check("R4 addr readback", v, {16'b0, val});
      end else begin
        rd(2'd2, v); check("R5 data readback", v, {16'b0, val});
      end
    end

    // R3 address write in clause 22 mode sends nothing
    wr(2'd0, cfgw(1'b0, 1'b0, 2));
    r0 = rises;
    wr(2'd3, 32'h0000ABCD);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check("R3 no frame busy", v[0], 1'b0);
    check("R3 no mdc", rises - r0, 0);
    rd(2'd3, v); check("R3 addr stored", v, 32'h0000ABCD);

    // R8 absent PHY
    phy_present = 1'b0;
    wr(2'd1, {16'b0, 1'b1, 2'b0, 5'h02, 3'b0, 5'h03});
    wait_idle();
    rd(2'd0, v); check("R8 error flag", v[1], 1'b1);
    rd(2'd2, v); check("R8 data ones", v, 32'h0000FFFF);
    phy_present = 1'b1;
    phy_rdata = 16'h0F0F;
    wr(2'd1, {16'b0, 1'b1, 2'b0, 5'h02, 3'b0, 5'h03});
    wait_idle();
    rd(2'd0, v); check("R8 error cleared", v[1], 1'b0);
    rd(2'd2, v); check("R8 data after recovery", v, 32'h00000F0F);

    // R9 half period of 3 clocks
    wr(2'd0, cfgw(1'b0, 1'b0, 3));
    wr(2'd2, 32'h00005555);
    while (!mdc) @(negedge clk);
    cnt = 0;
    while (mdc) begin cnt++; @(negedge clk); end
    check("R9 half period", cnt, 3);
    wait_idle();

    // R9 divider zero stalls; R11 writes while busy ignored
    wr(2'd0, cfgw(1'b0, 1'b0, 0));
    wr(2'd1, {19'b0, 5'h01, 3'b0, 5'h02});
    r0 = rises;
    wr(2'd2, 32'h00001111);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (mdc) cnt++; end
    check("R9 mdc held low", cnt, 0);
    rd(2'd0, v); check("R9 stalled busy", v[0], 1'b1);
    wr(2'd2, 32'h00002222);
    wr(2'd1, {16'b0, 1'b1, 2'b0, 5'h07, 3'b0, 5'h07});
    wr(2'd3, 32'h00003333);
    rd(2'd1, v); check("R11 ctl ignored", v, {19'b0, 5'h01, 3'b0, 5'h02});
    rd(2'd2, v); check("R11 data ignored", v, 32'h00001111);
    wr(2'd0, cfgw(1'b0, 1'b0, 2));
    rd(2'd0, v); check("R11 cfg taken while busy", v[24:16], 9'd2);
    wait_idle();
    check("R11 frame unchanged", cap[31:0], 32'h508A1111);
    check("R9 resumed frame rises", rises - r0, 64);
    rd(2'd3, v); check("R11 addr ignored", v, 32'h0000ABCD);

    check("R10 mdio edges", bad_edges, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule